// File: doc/BRIEF.md
# Serial FIFO Status Flags and Interrupt Gate

This block keeps the eight status flags of a FIFO-buffered serial port and turns them into four registered interrupt requests: transmit, receive, line break and receive error. The FIFO and line logic around it send single-cycle event pulses that set flags. They also send three level conditions: transmit trigger met, receive trigger met, and receive FIFO not empty. A host reads the flags through a status port and clears them by writing the status register.

Clearing is a handshake. A host read arms every flag that is 1 at that moment. A later write of 0 to an armed, clearable bit clears it. A flag that an event raises again after the read loses its arm, so a write based on a stale read cannot lose it. The three level-backed flags stay set while their condition holds. The interrupt enables come in as plain inputs from a control register kept elsewhere.

Top module: `uart_status_irq`

## Requirements
- R1: After reset the status reads 0x0060 (transmit-end bit 6 and transmit-empty bit 5 set, all others 0) and all four interrupt outputs are 0.
- R2: Each event pulse sets its own status bit: receive error bit 7, transmit end bit 6, transmit empty bit 5, break bit 4, framing error bit 3, parity error bit 2, receive full bit 1, data ready bit 0. Status bits 15..8 read 0.
- R3: A write with bit n = 0 clears flag n when n is one of the clearable bits (7, 6, 5, 4, 1, 0) and flag n read as 1 at the latest status read. A write with bit n = 1 leaves flag n unchanged.
- R4: A write does not clear a flag that was not read as 1 at the latest read. This includes a flag that an event set again after that read, and a flag that an event set in the same cycle as the read.
- R5: Writes never clear framing error (bit 3) or parity error (bit 2).
- R6: Receive full stays set while the receive trigger level is met. Transmit empty stays set while the transmit trigger level is met. Data ready stays set while the receive FIFO is not empty.
- R7: When an event sets a flag in the same cycle as a write that would clear it, the flag ends up set.
- R8: The transmit interrupt is transmit-empty AND the transmit interrupt enable.
- R9: The receive interrupt is (receive full OR data ready) AND the receive interrupt enable.
- R10: The break interrupt is the break flag, and the error interrupt is the OR of receive error, framing error and parity error. Each is gated by (receive interrupt enable OR receive-error interrupt enable).
- R11: The interrupt outputs are registered. They show a flag change or an enable change at the same clock edge that updates the flag or samples the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stsRdEn | input | 1 | Host status read strobe (arms flags) |
| stsWrEn | input | 1 | Host status write strobe |
| stsWrData | input | 8 | Host write data, 0 requests a clear |
| stsRdData | output | STS_W (16) | Status register value |
| evtRxErr | input | 1 | Receive error event pulse |
| evtTxEnd | input | 1 | Transmit end event pulse |
| evtTxEmpty | input | 1 | Transmit trigger reached pulse |
| evtBreak | input | 1 | Break detected pulse |
| evtFrameErr | input | 1 | Framing error pulse |
| evtParityErr | input | 1 | Parity error pulse |
| evtRxFull | input | 1 | Receive trigger reached pulse |
| evtDataReady | input | 1 | Data ready pulse |
| lvlTxTrig | input | 1 | Transmit trigger condition holds |
| lvlRxTrig | input | 1 | Receive trigger condition holds |
| lvlRxNotEmpty | input | 1 | Receive FIFO holds data |
| ctlTxIntEn | input | 1 | Transmit interrupt enable |
| ctlRxIntEn | input | 1 | Receive interrupt enable |
| ctlRxErrIntEn | input | 1 | Receive-error interrupt enable |
| irqTx | output | 1 | Transmit interrupt request |
| irqRx | output | 1 | Receive interrupt request |
| irqBreak | output | 1 | Break interrupt request |
| irqErr | output | 1 | Error interrupt request |

## Verification
A wrong arm bit does not show until a later write either clears a flag it should keep or fails to clear one. The bench therefore follows each read with writes and checks the status port at the next edge. A lost or stuck flag shows on the status port and on the gated interrupt one edge after the event or write. Same-cycle collisions of event, read and write are checked for both the flag and the arm that the next write exposes.

// File: rtl/uart_status_irq_pkg.sv
package uart_status_irq_pkg;
  localparam int FLAG_W = 8;
  localparam int BIT_DR    = 0;
  localparam int BIT_RDF   = 1;
  localparam int BIT_PER   = 2;
  localparam int BIT_FER   = 3;
  localparam int BIT_BRK   = 4;
  localparam int BIT_TDFE  = 5;
  localparam int BIT_TEND  = 6;
  localparam int BIT_RXERR = 7;
  localparam logic [FLAG_W-1:0] CLEARABLE   = 8'hF3;
  localparam logic [FLAG_W-1:0] FLAGS_RESET = 8'h60;

  typedef struct packed {
    logic [FLAG_W-1:0] setMask;
    logic [FLAG_W-1:0] clrMask;
    logic              captureRead;
  } flagStrobe_t;
endpackage

// File: rtl/uart_status_ctrl.sv
module uart_status_ctrl
  import uart_status_irq_pkg::*;
(
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [FLAG_W-1:0] wrData,
  input  logic [FLAG_W-1:0] evt,
  input  logic              lvlTxTrig,
  input  logic              lvlRxTrig,
  input  logic              lvlRxNotEmpty,
  input  logic [FLAG_W-1:0] armed,
  output flagStrobe_t       strb
);
  logic [FLAG_W-1:0] keepMask;

  always_comb begin
    // a bit survives unless written 0, clearable and armed
    keepMask = wrData | ~CLEARABLE | ~armed;
    if (lvlRxTrig)     keepMask[BIT_RDF]  = 1'b1;
    if (lvlTxTrig)     keepMask[BIT_TDFE] = 1'b1;
    if (lvlRxNotEmpty) keepMask[BIT_DR]   = 1'b1;
    strb.setMask     = evt;
    strb.clrMask     = wrEn ? ~keepMask : '0;
    strb.captureRead = rdEn;
  end
endmodule

// File: rtl/uart_status_flags.sv
module uart_status_flags
  import uart_status_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strb,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] flagsNext,
  output logic [FLAG_W-1:0] armed
);
  logic [FLAG_W-1:0] armedNext;

  always_comb begin
    flagsNext = (flags & ~strb.clrMask) | strb.setMask;
    if (strb.captureRead) armedNext = flags & ~strb.setMask;
    else                  armedNext = armed & ~strb.clrMask & ~strb.setMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= FLAGS_RESET;
      armed <= '0;
    end else begin
      flags <= flagsNext;
      armed <= armedNext;
    end
  end

  // R7: an event always leaves its flag set
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setMask != '0) |=> ((flags & $past(strb.setMask)) == $past(strb.setMask)));

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bitChk
    if (CLEARABLE[i]) begin : g_clr
      // R4: an unarmed flag cannot be cleared
      assert_unarmed_keep_R4: assert property (@(posedge clk) disable iff (!rstN)
        (flags[i] && !armed[i] && !strb.captureRead) |=> flags[i]);
    end else begin : g_sticky
      // R5: non-clearable flags never drop
      assert_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
        flags[i] |=> flags[i]);
    end
  end
endmodule

// File: rtl/uart_status_irqgate.sv
module uart_status_irqgate
  import uart_status_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] flagsNext,
  input  logic              txEn,
  input  logic              rxEn,
  input  logic              rxErrEn,
  output logic              irqTx,
  output logic              irqRx,
  output logic              irqBreak,
  output logic              irqErr
);
  logic lineEn;
  assign lineEn = rxEn | rxErrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqTx    <= 1'b0;
      irqRx    <= 1'b0;
      irqBreak <= 1'b0;
      irqErr   <= 1'b0;
    end else begin
      irqTx    <= flagsNext[BIT_TDFE] & txEn;
      irqRx    <= (flagsNext[BIT_RDF] | flagsNext[BIT_DR]) & rxEn;
      irqBreak <= flagsNext[BIT_BRK] & lineEn;
      irqErr   <= (flagsNext[BIT_RXERR] | flagsNext[BIT_FER] | flagsNext[BIT_PER]) & lineEn;
    end
  end

  assert_tx_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> !irqTx);
  assert_rx_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> !irqRx);
  assert_line_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    !lineEn |=> (!irqBreak && !irqErr));
endmodule

// File: rtl/uart_status_irq.sv
module uart_status_irq
  import uart_status_irq_pkg::*;
#(
  parameter int STS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stsRdEn,
  input  logic             stsWrEn,
  input  logic [7:0]       stsWrData,
  output logic [STS_W-1:0] stsRdData,
  input  logic             evtRxErr,
  input  logic             evtTxEnd,
  input  logic             evtTxEmpty,
  input  logic             evtBreak,
  input  logic             evtFrameErr,
  input  logic             evtParityErr,
  input  logic             evtRxFull,
  input  logic             evtDataReady,
  input  logic             lvlTxTrig,
  input  logic             lvlRxTrig,
  input  logic             lvlRxNotEmpty,
  input  logic             ctlTxIntEn,
  input  logic             ctlRxIntEn,
  input  logic             ctlRxErrIntEn,
  output logic             irqTx,
  output logic             irqRx,
  output logic             irqBreak,
  output logic             irqErr
);
  localparam int PAD_W = STS_W - FLAG_W;

  flagStrobe_t       strb;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] flagsNext;
  logic [FLAG_W-1:0] armed;
  logic [FLAG_W-1:0] evtVec;

  assign evtVec = {evtRxErr, evtTxEnd, evtTxEmpty, evtBreak,
                   evtFrameErr, evtParityErr, evtRxFull, evtDataReady};
  assign stsRdData = {{PAD_W{1'b0}}, flags};

  uart_status_ctrl u_ctrl (
    .rdEn(stsRdEn), .wrEn(stsWrEn), .wrData(stsWrData), .evt(evtVec),
    .lvlTxTrig(lvlTxTrig), .lvlRxTrig(lvlRxTrig), .lvlRxNotEmpty(lvlRxNotEmpty),
    .armed(armed), .strb(strb)
  );

  uart_status_flags u_flags (
    .clk(clk), .rstN(rstN), .strb(strb),
    .flags(flags), .flagsNext(flagsNext), .armed(armed)
  );

  uart_status_irqgate u_irq (
    .clk(clk), .rstN(rstN), .flagsNext(flagsNext),
    .txEn(ctlTxIntEn), .rxEn(ctlRxIntEn), .rxErrEn(ctlRxErrIntEn),
    .irqTx(irqTx), .irqRx(irqRx), .irqBreak(irqBreak), .irqErr(irqErr)
  );

  // R6: level-backed flags survive while their condition holds
  assert_dr_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lvlRxNotEmpty && flags[BIT_DR]) |=> flags[BIT_DR]);
  assert_rdf_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lvlRxTrig && flags[BIT_RDF]) |=> flags[BIT_RDF]);
  assert_tdfe_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lvlTxTrig && flags[BIT_TDFE]) |=> flags[BIT_TDFE]);
endmodule

// File: tb/uart_status_irq_tb.sv
module uart_status_irq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stsRdEn = 1'b0, stsWrEn = 1'b0;
  logic [7:0] stsWrData = 8'h00;
  logic [15:0] stsRdData;
  logic [7:0] ev = 8'h00;
  logic [2:0] lv = 3'b000;
  logic [2:0] en = 3'b000;
  logic irqTx, irqRx, irqBreak, irqErr;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_status_irq u_dut (
    .clk(clk), .rstN(rstN), .stsRdEn(stsRdEn), .stsWrEn(stsWrEn),
    .stsWrData(stsWrData), .stsRdData(stsRdData),
    .evtRxErr(ev[7]), .evtTxEnd(ev[6]), .evtTxEmpty(ev[5]), .evtBreak(ev[4]),
    .evtFrameErr(ev[3]), .evtParityErr(ev[2]), .evtRxFull(ev[1]), .evtDataReady(ev[0]),
    .lvlTxTrig(lv[2]), .lvlRxTrig(lv[1]), .lvlRxNotEmpty(lv[0]),
    .ctlTxIntEn(en[2]), .ctlRxIntEn(en[1]), .ctlRxErrIntEn(en[0]),
    .irqTx(irqTx), .irqRx(irqRx), .irqBreak(irqBreak), .irqErr(irqErr)
  );

  // {req, rd, wr, wdata, events, levels{tx,rx,ne}, enables{tx,rx,rxerr}, expStatus, expIrq{tx,rx,brk,err}}
  localparam int NV = 29;
  localparam logic [39:0] VEC [NV] = '{
    {4'd1,  1'b0,1'b0,8'h00,8'h00,3'b000,3'b000,8'h60,4'h0}, // R1 idle
    {4'd4,  1'b0,1'b1,8'h00,8'h00,3'b000,3'b000,8'h60,4'h0}, // R4 write without read
    {4'd8,  1'b0,1'b0,8'h00,8'h00,3'b000,3'b100,8'h60,4'h8}, // R8 tx enable
    {4'd3,  1'b1,1'b0,8'h00,8'h00,3'b000,3'b100,8'h60,4'h8}, // R3 read arms
    {4'd3,  1'b0,1'b1,8'hDF,8'h00,3'b000,3'b100,8'h40,4'h0}, // R3 clear bit 5 only
    {4'd3,  1'b0,1'b1,8'h00,8'h00,3'b000,3'b100,8'h00,4'h0}, // R3 clear bit 6
    {4'd9,  1'b0,1'b0,8'h00,8'h03,3'b000,3'b010,8'h03,4'h4}, // R9 rx full + ready
    {4'd6,  1'b1,1'b0,8'h00,8'h00,3'b011,3'b010,8'h03,4'h4}, // R6 read
    {4'd6,  1'b0,1'b1,8'h00,8'h00,3'b011,3'b010,8'h03,4'h4}, // R6 held by levels
    {4'd6,  1'b0,1'b1,8'h00,8'h00,3'b000,3'b010,8'h00,4'h0}, // R6 levels gone
    {4'd10, 1'b0,1'b0,8'h00,8'h10,3'b000,3'b001,8'h10,4'h2}, // R10 break
    {4'd10, 1'b1,1'b0,8'h00,8'h00,3'b000,3'b001,8'h10,4'h2}, // R10 read
    {4'd7,  1'b0,1'b1,8'h00,8'h10,3'b000,3'b001,8'h10,4'h2}, // R7 set beats clear
    {4'd4,  1'b0,1'b1,8'h00,8'h00,3'b000,3'b001,8'h10,4'h2}, // R4 re-set disarmed
    {4'd3,  1'b1,1'b0,8'h00,8'h00,3'b000,3'b001,8'h10,4'h2}, // R3 read
    {4'd3,  1'b0,1'b1,8'hEF,8'h00,3'b000,3'b001,8'h00,4'h0}, // R3 clear break
    {4'd10, 1'b0,1'b0,8'h00,8'h0C,3'b000,3'b010,8'h0C,4'h1}, // R10 frame+parity
    {4'd5,  1'b1,1'b0,8'h00,8'h00,3'b000,3'b010,8'h0C,4'h1}, // R5 read
    {4'd5,  1'b0,1'b1,8'h00,8'h00,3'b000,3'b010,8'h0C,4'h1}, // R5 not clearable
    {4'd11, 1'b0,1'b0,8'h00,8'h00,3'b000,3'b000,8'h0C,4'h0}, // R11 enable drop
    {4'd2,  1'b0,1'b0,8'h00,8'h80,3'b000,3'b001,8'h8C,4'h1}, // R2 rx error
    {4'd2,  1'b1,1'b0,8'h00,8'h00,3'b000,3'b001,8'h8C,4'h1}, // R2 read
    {4'd3,  1'b0,1'b1,8'h00,8'h00,3'b000,3'b001,8'h0C,4'h1}, // R3 clear bit 7
    {4'd2,  1'b0,1'b0,8'h00,8'h60,3'b100,3'b100,8'h6C,4'h8}, // R2 tx end + empty
    {4'd6,  1'b1,1'b0,8'h00,8'h00,3'b100,3'b100,8'h6C,4'h8}, // R6 read
    {4'd6,  1'b0,1'b1,8'h00,8'h00,3'b100,3'b100,8'h2C,4'h8}, // R6 tx empty held
    {4'd6,  1'b0,1'b1,8'h00,8'h00,3'b000,3'b100,8'h0C,4'h0}, // R6 released
    {4'd4,  1'b1,1'b0,8'h00,8'h01,3'b000,3'b010,8'h0D,4'h5}, // R4 read + event
    {4'd4,  1'b0,1'b1,8'h00,8'h00,3'b000,3'b010,8'h0D,4'h5}  // R4 not armed
  };

  task automatic check(input string req, input logic [15:0] st, input logic [3:0] irq);
    total++;
    if (stsRdData !== st) begin
      bad++;
      $display("FAIL %s status actual=%h expected=%h", req, stsRdData, st);
    end
    total++;
    if ({irqTx, irqRx, irqBreak, irqErr} !== irq) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", req, {irqTx, irqRx, irqBreak, irqErr}, irq);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 16'h0060, 4'h0);  // R1 during reset
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 16'h0060, 4'h0);  // R1 after release
    for (int i = 0; i < NV; i++) begin
      stsRdEn   = VEC[i][35];
      stsWrEn   = VEC[i][34];
      stsWrData = VEC[i][33:26];
      ev        = VEC[i][25:18];
      lv        = VEC[i][17:15];
      en        = VEC[i][14:12];
      @(negedge clk);
      check($sformatf("R%0d row%0d", VEC[i][39:36], i), {8'h00, VEC[i][11:4]}, VEC[i][3:0]);
    end
    stsRdEn = 1'b0; stsWrEn = 1'b0; ev = 8'h00; lv = 3'b000; en = 3'b111;
    // R1: mid-run reset restores the flags and silences interrupts
    rstN = 1'b0;
    #1;
    check("R1", 16'h0060, 4'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: after reset with all enables, transmit-empty raises irqTx only
    check("R8", 16'h0060, 4'h8);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule